// File: doc/BRIEF.md
# Register Bank Read-Port Conflict Checker

This block inspects one issue bundle of a four-lane vector VLIW core before the bundle reads its register file. Each lane carries one two-source ALU operation, and every source is tagged with where its value comes from. The sources can be a component of a general register, the forwarded result of the previous vector operation, the forwarded result of the previous scalar operation, a component of a temporary register, or a literal. Only the general register file is split into component banks (x, y, z, w), and each bank serves a limited number of reads per cycle. The other sources bypass the banks entirely.

The checker counts the distinct bank reads that the bundle makes on each bank. It then works out how many extra read cycles the bundle needs when any bank is oversubscribed, and raises a conflict flag when that number is nonzero. The issue stage offers a bundle on a valid/ready handshake. One clock after acceptance, the result appears on a second valid/ready handshake and stays there until the consumer takes it. The issue logic uses the extra-cycle count to stretch the register-read phase, or the compiler back end uses it to re-pack a bundle.

Top module: `vliw_bank_checker`

## Requirements
- R1: Source operand o = 2*lane + slot (slot 0 or 1) is tagged by src_kind[3o+:3], src_comp[2o+:2] and src_reg[7o+:7]. A kind of 0 (general register) reads the bank selected by its component code, where 0=x, 1=y, 2=z and 3=w. bank_cnt[4b+:4] reports the number of such reads on bank b.
- R2: Sources of kind 1 (forwarded previous-vector result) and kind 2 (forwarded previous-scalar result) add nothing to any bank count, whatever their component code.
- R3: Sources of kind 3 (temporary register component) add nothing to any bank count.
- R4: Sources of kind 4 (literal) add nothing to any bank count. Codes 5 to 7 are reserved and also add nothing.
- R5: General-register sources with identical register index and component, anywhere in the bundle, count as one read. The same index with a different component counts separately, and so does the same component with a different index.
- R6: Both sources of a lane whose lane_en bit is 0 add nothing to any bank count.
- R7: extra_cycles equals ceil(M/3) - 1, where M is the largest of the four bank counts. It is 0 when M is 0.
- R8: conflict is 1 exactly when extra_cycles is nonzero, which is when some bank count exceeds 3.
- R9: A bundle is accepted on a rising clock edge with in_valid and in_ready both high. At the next edge, out_valid is high and carries that bundle's results.
- R10: While out_valid is high and out_ready is low, in_ready is low and all result outputs hold their values. A result consumed in the same cycle that a new bundle is accepted is replaced by the new bundle's results without a gap.
- R11: After reset, out_valid is low, in_ready is high and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Checker can accept a bundle |
| lane_en | input | 4 | Per-lane operation enable |
| src_kind | input | 24 | Source kind code per operand, 3 bits each |
| src_comp | input | 16 | Component code per operand, 2 bits each |
| src_reg | input | 56 | Register index per operand, 7 bits each |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| bank_cnt | output | 16 | Read count per bank, 4 bits each, bank 0 = x |
| conflict | output | 1 | Bundle oversubscribes a bank |
| extra_cycles | output | 2 | Additional read cycles the bundle needs |

## Verification
The assertions assume that the inputs obey the handshake in the usual way and that nothing is X while rst_n is high. They do not assume that the operand fields stay stable while in_valid waits: a stalled bundle is sampled only at the edge where it is accepted. The stimulus changes inputs only on falling edges and presents new operand fields only between bundles. In the back-pressure scenario it holds a second bundle steady while the first one waits, so the accept-and-replace edge is exercised with stable inputs. Register indices stay inside the 7-bit field and all kind codes are legal or reserved values from R4.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        SRC_GPR  = 3'd0,
        SRC_PVEC = 3'd1,
        SRC_PSCL = 3'd2,
        SRC_TEMP = 3'd3,
        SRC_LIT  = 3'd4
    } src_kind_e;

endpackage

// File: rtl/vbc_operand_filter.sv
// Marks every source operand that costs a bank read port: an enabled
// general-register source that is not a repeat of an earlier one.
module vbc_operand_filter
    import vbc_pkg::*;
#(
    parameter int OPS    = 8,
    parameter int COMP_W = 2,
    parameter int REG_AW = 7
) (
    input  logic [OPS-1:0]        op_en,
    input  logic [OPS*KIND_W-1:0] kind_flat,
    input  logic [OPS*COMP_W-1:0] comp_flat,
    input  logic [OPS*REG_AW-1:0] reg_flat,
    output logic [OPS-1:0]        rd_mask
);

    logic              is_gpr [OPS];
    logic [COMP_W-1:0] comp_a [OPS];
    logic [REG_AW-1:0] reg_a  [OPS];

    for (genvar i = 0; i < OPS; i++) begin : g_dec
        assign is_gpr[i] = op_en[i] && (kind_flat[i*KIND_W +: KIND_W] == SRC_GPR);
        assign comp_a[i] = comp_flat[i*COMP_W +: COMP_W];
        assign reg_a[i]  = reg_flat[i*REG_AW +: REG_AW];
    end

    // An operand is a repeat when an earlier general-register operand
    // names the same register and component; only the first one reads.
    for (genvar i = 0; i < OPS; i++) begin : g_dup
        logic seen_d;
        always_comb begin
            seen_d = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (is_gpr[j] && (reg_a[j] == reg_a[i]) && (comp_a[j] == comp_a[i])) begin
                    seen_d = 1'b1;
                end
            end
        end
        assign rd_mask[i] = is_gpr[i] && !seen_d;
    end

endmodule

// File: rtl/vbc_bank_tally.sv
// Counts the marked reads per component bank and finds the busiest bank.
module vbc_bank_tally #(
    parameter int OPS    = 8,
    parameter int NBANKS = 4,
    parameter int COMP_W = 2,
    parameter int CW     = 4
) (
    input  logic [OPS-1:0]        rd_mask,
    input  logic [OPS*COMP_W-1:0] comp_flat,
    output logic [NBANKS*CW-1:0]  bank_cnt,
    output logic [CW-1:0]         max_cnt
);

    logic [CW-1:0] cnt_a [NBANKS];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        always_comb begin
            cnt_a[b] = '0;
            for (int o = 0; o < OPS; o++) begin
                if (rd_mask[o] && (comp_flat[o*COMP_W +: COMP_W] == COMP_W'(b))) begin
                    cnt_a[b] = cnt_a[b] + CW'(1);
                end
            end
        end
        assign bank_cnt[b*CW +: CW] = cnt_a[b];
    end

    always_comb begin
        max_cnt = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (cnt_a[b] > max_cnt) begin
                max_cnt = cnt_a[b];
            end
        end
    end

endmodule

// File: rtl/vbc_cycle_calc.sv
// Converts the busiest bank's load into extra read cycles and a flag.
module vbc_cycle_calc #(
    parameter int CW    = 4,
    parameter int LIMIT = 3,
    parameter int EW    = 2
) (
    input  logic [CW-1:0] max_cnt,
    output logic [EW-1:0] extra,
    output logic          conflict
);

    // ceil(m/L) - 1 == floor((m-1)/L) for m >= 1
    always_comb begin
        if (max_cnt == '0) begin
            extra = '0;
        end else begin
            extra = EW'((int'(max_cnt) - 1) / LIMIT);
        end
    end

    // Derived from the raw count, not from the quotient above.
    assign conflict = int'(max_cnt) > LIMIT;

endmodule

// File: rtl/vliw_bank_checker.sv
module vliw_bank_checker
    import vbc_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int NBANKS    = 4,
    parameter int REG_AW    = 7,
    parameter int READ_LIM  = 3,
    parameter int OPS       = LANES * 2,
    parameter int COMP_W    = $clog2(NBANKS),
    parameter int CW        = $clog2(OPS + 1),
    parameter int MAX_EXTRA = (OPS + READ_LIM - 1) / READ_LIM - 1,
    parameter int EW        = (MAX_EXTRA < 1) ? 1 : $clog2(MAX_EXTRA + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANES-1:0]         lane_en,
    input  logic [OPS*KIND_W-1:0]    src_kind,
    input  logic [OPS*COMP_W-1:0]    src_comp,
    input  logic [OPS*REG_AW-1:0]    src_reg,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [NBANKS*CW-1:0]     bank_cnt,
    output logic                     conflict,
    output logic [EW-1:0]            extra_cycles
);

    typedef struct packed {
        logic                 vld;
        logic [NBANKS*CW-1:0] cnt;
        logic                 conf;
        logic [EW-1:0]        extra;
    } res_t;

    res_t res_d, res_q;

    logic [OPS-1:0]        op_en;
    logic [OPS-1:0]        rd_mask;
    logic [NBANKS*CW-1:0]  cnt_c;
    logic [CW-1:0]         max_c;
    logic [EW-1:0]         extra_c;
    logic                  conf_c;
    logic                  accept;

    for (genvar o = 0; o < OPS; o++) begin : g_en
        assign op_en[o] = lane_en[o / 2];
    end

    vbc_operand_filter #(
        .OPS    (OPS),
        .COMP_W (COMP_W),
        .REG_AW (REG_AW)
    ) u_filter (
        .op_en     (op_en),
        .kind_flat (src_kind),
        .comp_flat (src_comp),
        .reg_flat  (src_reg),
        .rd_mask   (rd_mask)
    );

    vbc_bank_tally #(
        .OPS    (OPS),
        .NBANKS (NBANKS),
        .COMP_W (COMP_W),
        .CW     (CW)
    ) u_tally (
        .rd_mask   (rd_mask),
        .comp_flat (src_comp),
        .bank_cnt  (cnt_c),
        .max_cnt   (max_c)
    );

    vbc_cycle_calc #(
        .CW    (CW),
        .LIMIT (READ_LIM),
        .EW    (EW)
    ) u_calc (
        .max_cnt  (max_c),
        .extra    (extra_c),
        .conflict (conf_c)
    );

    assign in_ready = !res_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        res_d = res_q;
        if (accept) begin
            res_d.vld   = 1'b1;
            res_d.cnt   = cnt_c;
            res_d.conf  = conf_c;
            res_d.extra = extra_c;
        end else if (out_ready) begin
            res_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.vld;
    assign bank_cnt     = res_q.cnt;
    assign conflict     = res_q.conf;
    assign extra_cycles = res_q.extra;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic [CW+3:0] total_out;
    always_comb begin
        total_out = '0;
        for (int b = 0; b < NBANKS; b++) begin
            total_out = total_out + (CW+4)'(bank_cnt[b*CW +: CW]);
        end
    end

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(bank_cnt)
                                    && $stable(conflict) && $stable(extra_cycles));

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (conflict == (extra_cycles != '0)));

    p_extra_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(extra_cycles) <= MAX_EXTRA));

    p_lane_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> int'(total_out) <= 2 * $countones($past(lane_en)));

endmodule

// File: tb/tb_vliw_bank_checker.sv
module tb_vliw_bank_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  lane_en = '0;
    logic [23:0] src_kind = '0;
    logic [15:0] src_comp = '0;
    logic [55:0] src_reg = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] bank_cnt;
    logic        conflict;
    logic [1:0]  extra_cycles;

    int n_chk = 0;
    int n_bad = 0;

    int k_a [8];
    int c_a [8];
    int r_a [8];

    int exp_cnt [4];
    int exp_extra;
    int exp_conf;

    always #2 clk = ~clk;

    vliw_bank_checker dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .lane_en      (lane_en),
        .src_kind     (src_kind),
        .src_comp     (src_comp),
        .src_reg      (src_reg),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .bank_cnt     (bank_cnt),
        .conflict     (conflict),
        .extra_cycles (extra_cycles)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_op(int o, int kind, int comp, int idx);
        k_a[o] = kind;
        c_a[o] = comp;
        r_a[o] = idx;
    endtask

    task automatic pack_ops();
        for (int o = 0; o < 8; o++) begin
            src_kind[o*3 +: 3] = 3'(k_a[o]);
            src_comp[o*2 +: 2] = 2'(c_a[o]);
            src_reg[o*7 +: 7]  = 7'(r_a[o]);
        end
    endtask

    // Reference from the written rules
    task automatic model();
        int m;
        for (int b = 0; b < 4; b++) exp_cnt[b] = 0;
        for (int o = 0; o < 8; o++) begin
            bit first = 1'b1;
            if (!lane_en[o/2] || k_a[o] != 0) continue;
            for (int p = 0; p < o; p++) begin
                if (lane_en[p/2] && k_a[p] == 0 && r_a[p] == r_a[o] && c_a[p] == c_a[o])
                    first = 1'b0;
            end
            if (first) exp_cnt[c_a[o]]++;
        end
        m = 0;
        for (int b = 0; b < 4; b++) if (exp_cnt[b] > m) m = exp_cnt[b];
        exp_extra = (m == 0) ? 0 : (m + 2) / 3 - 1;
        exp_conf  = (exp_extra != 0) ? 1 : 0;
    endtask

    task automatic check_result(string req);
        for (int b = 0; b < 4; b++)
            check(req, $sformatf("bank %0d count", b), int'(bank_cnt[b*4 +: 4]), exp_cnt[b]);
        check(req, "extra_cycles", int'(extra_cycles), exp_extra);
        check(req, "conflict", int'(conflict), exp_conf);
    endtask

    // Offer one bundle, sample the result one cycle later.
    task automatic apply(string req);
        pack_ops();
        model();
        @(negedge clk);
        in_valid = 1'b1;
        check(req, "in_ready at offer", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid after accept", int'(out_valid), 1);
        check_result(req);
        @(negedge clk);
    endtask

    task automatic fill(int kind, int comp);
        for (int o = 0; o < 8; o++) set_op(o, kind, comp, o + 10);
    endtask

    task automatic t_reset();
        check("R11", "out_valid", int'(out_valid), 0);
        check("R11", "in_ready", int'(in_ready), 1);
        check("R11", "bank_cnt", int'(bank_cnt), 0);
        check("R11", "extra_cycles", int'(extra_cycles), 0);
        check("R11", "conflict", int'(conflict), 0);
    endtask

    task automatic t_single_bank();
        lane_en = 4'hF;
        fill(0, 0);
        apply("R1 R7 all eight on x");
        fill(0, 3);
        apply("R1 R8 all eight on w");
    endtask

    task automatic t_spread();
        lane_en = 4'hF;
        for (int o = 0; o < 8; o++) set_op(o, 0, o % 4, o);
        apply("R1 spread two per bank");
        for (int o = 0; o < 8; o++) set_op(o, 0, (o < 3) ? 1 : 2, o);
        apply("R7 three on y five on z");
    endtask

    task automatic t_boundary();
        lane_en = 4'hF;
        fill(4, 0);
        for (int o = 0; o < 3; o++) set_op(o, 0, 2, o);
        apply("R7 exactly three on z");
        set_op(3, 0, 2, 3);
        apply("R8 four on z");
        for (int o = 0; o < 7; o++) set_op(o, 0, 2, o);
        apply("R7 seven on z");
    endtask

    task automatic t_bypass();
        lane_en = 4'hF;
        for (int o = 0; o < 8; o++) set_op(o, (o % 2) ? 2 : 1, 0, o);
        apply("R2 forwarded results");
        fill(3, 0);
        apply("R3 temporaries");
        for (int o = 0; o < 8; o++) set_op(o, 4 + (o % 4), 0, o);
        apply("R4 literals and reserved");
        for (int o = 0; o < 8; o++) set_op(o, (o < 4) ? 0 : 3, 1, o);
        apply("R3 half temp half general on y");
    endtask

    task automatic t_dup();
        lane_en = 4'hF;
        for (int o = 0; o < 8; o++) set_op(o, 0, 0, 5);
        apply("R5 same register same component");
        for (int o = 0; o < 8; o++) set_op(o, 0, o % 4, 5);
        apply("R5 same register four components");
        for (int o = 0; o < 8; o++) set_op(o, 0, 1, o / 2);
        apply("R5 pairs of repeats on y");
    endtask

    task automatic t_lanes();
        fill(0, 0);
        lane_en = 4'b0001;
        apply("R6 one lane enabled");
        lane_en = 4'b0000;
        apply("R6 no lane enabled");
        lane_en = 4'b1010;
        apply("R6 lanes one and three");
        for (int o = 0; o < 8; o++) set_op(o, 0, 0, (o < 2) ? 9 : 20 + o);
        lane_en = 4'b1110;
        set_op(2, 0, 0, 9);
        apply("R6 repeat of disabled lane counts");
    endtask

    task automatic t_backpressure();
        int first_cnt [4];
        int first_extra;
        int first_conf;
        lane_en = 4'hF;
        fill(0, 1);
        pack_ops();
        model();
        for (int b = 0; b < 4; b++) first_cnt[b] = exp_cnt[b];
        first_extra = exp_extra;
        first_conf  = exp_conf;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        check("R9", "out_valid before accept", int'(out_valid), 0);
        @(negedge clk);
        check("R9", "out_valid one cycle after accept", int'(out_valid), 1);
        // Second bundle waits behind the first.
        for (int o = 0; o < 8; o++) set_op(o, 0, o % 4, o + 40);
        pack_ops();
        for (int cyc = 0; cyc < 3; cyc++) begin
            @(negedge clk);
            check("R10", "in_ready during stall", int'(in_ready), 0);
            check("R10", "out_valid during stall", int'(out_valid), 1);
            for (int b = 0; b < 4; b++)
                check("R10", "held count", int'(bank_cnt[b*4 +: 4]), first_cnt[b]);
            check("R10", "held extra", int'(extra_cycles), first_extra);
            check("R10", "held conflict", int'(conflict), first_conf);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model();
        check("R10", "out_valid on replace", int'(out_valid), 1);
        check_result("R10 replaced result");
        @(negedge clk);
        check("R9", "out_valid after drain", int'(out_valid), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        for (int o = 0; o < 8; o++) set_op(o, 0, 0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bank();
        t_spread();
        t_boundary();
        t_bypass();
        t_dup();
        t_lanes();
        t_backpressure();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule